// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A 16-state controller advances on each rising edge of the test clock and is steered by the mode-select input. It routes the serial data input through one of four shift paths toward the serial data output. Those paths are a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification register and a boundary register. The boundary register has one cell per data pin, followed by one output-enable control cell.

The instruction in force determines three things: which data path sits between the serial pins, whether the memory's own output drivers are held in high impedance, and whether the boundary register takes over the data pads. The serial output changes only on falling test-clock edges and is enabled only while a shift state is active. The block uses a synchronous, active-high reset. Holding the mode-select input high for five clocks gives the same result as a reset.

Top module: `scan_tap`

## Requirements
- R1: After reset, and every time the controller passes through Test-Logic-Reset, the instruction in force is the identification code 001. The output-enable cell of the boundary update stage is also preset to 1 at these times.
- R2: Holding `tms` high for five consecutive rising edges of `tck` brings the controller to Test-Logic-Reset, whatever state it started in.
- R3: In Capture-IR the instruction shift register loads 3'b001, so its two low bits are 01. Shifting is least significant bit first, so the first three bits out on `tdo` are 1, 0, 0.
- R4: Code 001 selects the 32-bit identification register. That register shifts out least significant bit first, bit 0 always reads 1 whatever `ID_CODE[0]` holds, and `func_hiz` stays 0.
- R5: Code 000 (external test) selects the boundary register and drives `func_hiz` high. It also sets `pad_oe` to the update stage's output-enable cell and `pad_dout` to the update stage's data cells.
- R6: Code 010 (sample) selects the boundary register, drives `func_hiz` high and holds `pad_oe` at 0. In Capture-DR it loads `pin_in`.
- R7: Codes 011 through 111 select a 1-bit bypass stage. That stage captures 0, so `tdo` shows 0 first and then `tdi` delayed by one shift.
- R8: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR. Both `tdo` and `tdo_oe` change on the falling edge of `tck`.
- R9: The boundary register is `DATA_W`+1 cells long. Cell `i` (for `i` below `DATA_W`) belongs to data pin `i`, with cell 0 nearest `tdo`. The top cell, `DATA_W`, is the output-enable control. In Capture-DR that control cell reloads the current update-stage enable.
- R10: The instruction changes only at Update-IR or Test-Logic-Reset. The boundary update stage changes only at Update-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_in | input | DATA_W | Data pad levels, captured by the boundary register |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`; 0 means high impedance |
| func_hiz | output | 1 | Forces the memory's functional outputs to high impedance |
| pad_oe | output | 1 | Pad output enable from the boundary register under external test |
| pad_dout | output | DATA_W | Pad data from the boundary update stage |

## Verification
If the controller state is wrong, `tdo_oe` is wrong at the very next falling edge, because the enable follows the shift states directly. A wrong capture value appears as the first bit of the next shift. An instruction register that latched too early or too late is visible on `func_hiz` and `pad_oe` one cycle after the update point, while the controller is still parked in Pause-IR. A boundary cell in the wrong position appears as misordered bits on `tdo` and on `pad_dout`, within one full scan.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] INS_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] INS_IDCODE = 3'b001;
    localparam logic [IR_W-1:0] INS_SAMPLE = 3'b010;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS, PATH_ID, PATH_BOUND
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     hiz;
        logic     extest;
    } ins_dec_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic ins_dec_t ins_decode(input logic [IR_W-1:0] ins);
        ins_dec_t d;
        case (ins)
            INS_EXTEST: d = '{path: PATH_BOUND,  hiz: 1'b1, extest: 1'b1};
            INS_IDCODE: d = '{path: PATH_ID,     hiz: 1'b0, extest: 1'b0};
            INS_SAMPLE: d = '{path: PATH_BOUND,  hiz: 1'b1, extest: 1'b0};
            default:    d = '{path: PATH_BYPASS, hiz: 1'b0, extest: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ins_q,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sr <= '0;
        end else if (state == ST_CAP_IR) begin
            ir_sr <= {{(IR_W-2){1'b0}}, 2'b01};
        end else if (state == ST_SH_IR) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (rst || state == ST_RESET) ins_q <= INS_IDCODE;
        else if (state == ST_UPD_IR)  ins_q <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [31:0] ID_CODE = 32'h0A5C_6E3C
) (
    input  logic              tck,
    input  logic              rst,
    input  tap_state_e        state,
    input  logic              tdi,
    input  dr_path_e          path,
    input  logic [DATA_W-1:0] pin_in,
    output logic              dr_lsb,
    output logic [DATA_W-1:0] upd_data,
    output logic              upd_oe
);

    localparam int BS_LEN = DATA_W + 1;
    localparam int ID_W   = 32;
    localparam logic [ID_W-1:0] ID_VAL = {ID_CODE[ID_W-1:1], 1'b1};

    logic cap, sh, upd;
    assign cap = (state == ST_CAP_DR);
    assign sh  = (state == ST_SH_DR);
    assign upd = (state == ST_UPD_DR);

    // bypass stage
    logic byp_q;
    always_ff @(posedge tck) begin
        if (rst)                             byp_q <= 1'b0;
        else if (path == PATH_BYPASS && cap) byp_q <= 1'b0;
        else if (path == PATH_BYPASS && sh)  byp_q <= tdi;
    end

    // identification register
    logic [ID_W-1:0] id_sr;
    always_ff @(posedge tck) begin
        if (rst)                         id_sr <= ID_VAL;
        else if (path == PATH_ID && cap) id_sr <= ID_VAL;
        else if (path == PATH_ID && sh)  id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // boundary register: cells 0..DATA_W-1 are pins, cell DATA_W is enable
    logic [BS_LEN-1:0] bs_sr;
    logic [BS_LEN-1:0] bs_cap;
    logic [BS_LEN-1:0] bs_upd;
    logic              bs_sel;

    assign bs_sel = (path == PATH_BOUND);
    assign bs_cap = {bs_upd[BS_LEN-1], pin_in};

    for (genvar i = 0; i < BS_LEN; i++) begin : g_cell
        logic shift_src;
        if (i == BS_LEN - 1) begin : g_top
            assign shift_src = tdi;
        end else begin : g_mid
            assign shift_src = bs_sr[i+1];
        end

        always_ff @(posedge tck) begin
            if (rst)                bs_sr[i] <= (i == BS_LEN - 1);
            else if (bs_sel && cap) bs_sr[i] <= bs_cap[i];
            else if (bs_sel && sh)  bs_sr[i] <= shift_src;
        end

        always_ff @(posedge tck) begin
            if (rst || state == ST_RESET) begin
                if (i == BS_LEN - 1) bs_upd[i] <= 1'b1;
            end else if (bs_sel && upd) begin
                bs_upd[i] <= bs_sr[i];
            end
        end
    end

    assign upd_data = bs_upd[DATA_W-1:0];
    assign upd_oe   = bs_upd[BS_LEN-1];

    always_comb begin
        case (path)
            PATH_ID:    dr_lsb = id_sr[0];
            PATH_BOUND: dr_lsb = bs_sr[0];
            default:    dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import tap_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [31:0] ID_CODE = 32'h0A5C_6E3C
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              tms,
    input  logic              tdi,
    input  logic [DATA_W-1:0] pin_in,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              func_hiz,
    output logic              pad_oe,
    output logic [DATA_W-1:0] pad_dout
);

    tap_state_e      cur_st;
    logic [IR_W-1:0] ins_q;
    logic            ir_lsb;
    logic            dr_lsb;
    logic            bs_oe;
    ins_dec_t        dec;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (cur_st)
    );

    tap_ir u_ir (
        .tck    (tck),
        .rst    (rst),
        .state  (cur_st),
        .tdi    (tdi),
        .ins_q  (ins_q),
        .ir_lsb (ir_lsb)
    );

    assign dec = ins_decode(ins_q);

    tap_dr #(
        .DATA_W  (DATA_W),
        .ID_CODE (ID_CODE)
    ) u_dr (
        .tck      (tck),
        .rst      (rst),
        .state    (cur_st),
        .tdi      (tdi),
        .path     (dec.path),
        .pin_in   (pin_in),
        .dr_lsb   (dr_lsb),
        .upd_data (pad_dout),
        .upd_oe   (bs_oe)
    );

    // serial output retimed to the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (cur_st == ST_SH_IR) ? ir_lsb : dr_lsb;
            tdo_oe <= (cur_st == ST_SH_IR) || (cur_st == ST_SH_DR);
        end
    end

    assign func_hiz = dec.hiz;
    assign pad_oe   = dec.extest & bs_oe;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            rst,
    input logic            tms,
    input logic            tdo,
    input logic            tdo_oe,
    input logic            func_hiz,
    input logic            pad_oe,
    input tap_state_e      state,
    input logic [IR_W-1:0] ins_q,
    input logic            bs_oe
);

    logic [2:0] ones_cnt;
    always_ff @(posedge tck) begin
        if (rst)               ones_cnt <= '0;
        else if (!tms)         ones_cnt <= '0;
        else if (ones_cnt < 7) ones_cnt <= ones_cnt + 3'd1;
    end

    AST_RESET_LOADS_ID: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET) |=> (ins_q == INS_IDCODE));   // R1
    AST_RESET_OE_HIGH: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET) |=> bs_oe);   // R1
    AST_FIVE_ONES: assert property (@(posedge tck) disable iff (rst)
        (ones_cnt >= 3'd5) |-> (state == ST_RESET));   // R2
    AST_IR_CAPTURE_BIT: assert property (@(posedge tck) disable iff (rst)
        (state == ST_SH_IR && $past(state) == ST_CAP_IR) |-> (tdo && tdo_oe));   // R3
    AST_ID_NO_HIZ: assert property (@(posedge tck) disable iff (rst)
        (ins_q == INS_IDCODE) |-> !func_hiz);   // R4
    AST_BOUND_HIZ: assert property (@(posedge tck) disable iff (rst)
        (ins_q == INS_EXTEST || ins_q == INS_SAMPLE) |-> func_hiz);   // R5
    AST_PADS_ONLY_EXT: assert property (@(posedge tck) disable iff (rst)
        pad_oe |-> (ins_q == INS_EXTEST));   // R6
    AST_TDO_SHIFT_ONLY: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));   // R8
    AST_INS_HOLDS: assert property (@(posedge tck) disable iff (rst)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ins_q));   // R10

endmodule

bind scan_tap scan_tap_chk u_chk (
    .tck      (tck),
    .rst      (rst),
    .tms      (tms),
    .tdo      (tdo),
    .tdo_oe   (tdo_oe),
    .func_hiz (func_hiz),
    .pad_oe   (pad_oe),
    .state    (cur_st),
    .ins_q    (ins_q),
    .bs_oe    (bs_oe)
);

// File: tb/sim_scan_tap.sv
`timescale 1ns/1ps
module sim_scan_tap;

    localparam int          DATA_W = 8;
    localparam logic [31:0] ID_RAW = 32'h0A5C_6E3C;
    localparam logic [31:0] ID_EXP = {ID_RAW[31:1], 1'b1};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tms = 1'b1;
    logic              tdi = 1'b0;
    logic [DATA_W-1:0] pin_in = '0;
    logic              tdo, tdo_oe, func_hiz, pad_oe;
    logic [DATA_W-1:0] pad_dout;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    scan_tap #(.DATA_W(DATA_W), .ID_CODE(ID_RAW)) u0 (
        .tck(clk), .rst(rst), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .func_hiz(func_hiz),
        .pad_oe(pad_oe), .pad_dout(pad_dout)
    );

    typedef struct {
        bit    chk_tdo;
        bit    exp_tdo;
        bit    chk_oe;
        bit    exp_oe;
        string tag;
    } item_t;

    item_t sb_q[$];

    task automatic check(input logic [63:0] act, input logic [63:0] exp,
                         input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one item per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                if (it.chk_oe)  check(64'(tdo_oe), 64'(it.exp_oe), it.tag, "tdo_oe");
                if (it.chk_tdo) check(64'(tdo), 64'(it.exp_tdo), it.tag, "tdo");
            end
        end
    end

    // driver: one TCK cycle, inputs set after the falling edge
    task automatic tick(input bit m, input bit d, input bit ct, input bit et,
                        input bit co, input bit eo, input string tag);
        @(negedge clk);
        #1;
        tms = m;
        tdi = d;
        sb_q.push_back('{ct, et, co, eo, tag});
    endtask

    task automatic nav(input bit m);
        tick(m, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");   // R8: no drive outside shift
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    task automatic shift_ir(input logic [2:0] code);
        nav(1); nav(1); nav(0); nav(0);
        for (int i = 0; i < 3; i++)
            tick(i == 2, code[i], 1'b1, (i == 0), 1'b1, 1'b1, "R3");
        nav(1); nav(0);
        settle();
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din,
                            input logic [63:0] exp, input string tag);
        nav(1); nav(0); nav(0);
        for (int i = 0; i < n; i++)
            tick(i == n - 1, din[i], 1'b1, exp[i], 1'b1, 1'b1, tag);
        nav(1); nav(0);
        settle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 rst = 1'b0;
        settle();
        // R1: reset state
        check(64'(tdo_oe), 0, "R1", "tdo_oe after reset");
        check(64'(func_hiz), 0, "R1", "func_hiz after reset");
        check(64'(pad_oe), 0, "R1", "pad_oe after reset");
        nav(0);   // to Run-Test/Idle

        // R4: identification register after reset (R1 instruction)
        shift_dr(32, 64'hFFFF_FFFF, 64'(ID_EXP), "R4");
        check(64'(func_hiz), 0, "R4", "func_hiz under identify");

        // R5: external test
        pin_in = 8'h96;
        shift_ir(3'b000);
        check(64'(func_hiz), 1, "R5", "func_hiz under external test");
        shift_dr(9, {55'd0, 1'b1, 8'hA5}, {55'd0, 1'b1, 8'h96}, "R9");
        check(64'(pad_dout), 64'h00A5, "R5", "pad_dout");
        check(64'(pad_oe), 1, "R5", "pad_oe enabled");
        shift_dr(9, {55'd0, 1'b0, 8'h5A}, {55'd0, 1'b1, 8'h96}, "R9");
        check(64'(pad_oe), 0, "R5", "pad_oe cleared by enable cell");
        check(64'(pad_dout), 64'h005A, "R5", "pad_dout second");
        pin_in = 8'h3C;
        shift_dr(9, {55'd0, 1'b0, 8'h5A}, {55'd0, 1'b0, 8'h3C}, "R9");

        // R10: instruction holds while parked in Pause-IR
        nav(1); nav(1); nav(0); nav(0);
        tick(0, 1, 1, 1, 1, 1, "R3");
        tick(0, 0, 1, 0, 1, 1, "R3");
        tick(1, 0, 1, 0, 1, 1, "R3");   // code 001 shifted in
        nav(0); nav(0);
        settle();
        check(64'(func_hiz), 1, "R10", "func_hiz held before update");
        nav(1); nav(1); nav(0);
        settle();
        check(64'(func_hiz), 0, "R10", "func_hiz after update");

        // R6: sample
        shift_ir(3'b010);
        check(64'(func_hiz), 1, "R6", "func_hiz under sample");
        check(64'(pad_oe), 0, "R6", "pad_oe under sample");
        pin_in = 8'hC3;
        shift_dr(9, {55'd0, 1'b1, 8'h00}, {55'd0, 1'b0, 8'hC3}, "R6");
        check(64'(pad_oe), 0, "R6", "pad_oe stays off under sample");

        // R7: bypass codes
        shift_ir(3'b101);
        check(64'(func_hiz), 0, "R7", "func_hiz under bypass");
        shift_dr(4, 64'b1011, 64'b0110, "R7");
        shift_ir(3'b111);
        shift_dr(4, 64'b0101, 64'b1010, "R7");

        // R2: five TMS-high cycles from inside Shift-DR
        nav(1); nav(0); nav(0);
        tick(1, 0, 0, 0, 0, 0, "R2");
        repeat (4) nav(1);
        nav(0);
        settle();
        check(64'(func_hiz), 0, "R2", "func_hiz after TMS reset");
        shift_dr(32, 64'h0, 64'(ID_EXP), "R2");

        // R8: idle, no drive
        nav(0);
        settle();
        check(64'(tdo_oe), 0, "R8", "tdo_oe in idle");

        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule